// File: doc/BRIEF.md
# Storage Command Frame Sequencer

This block is the host-side command engine of a serial storage link. A requester hands it one operation at a time: direction, 48-bit starting sector address and sector count. The block turns it into the exchange of frames the device expects. It builds the five-word host-to-device register frame carrying the DMA command and streams it into the transmit FIFO that the link layer drains. On a write it answers each device activation with one data frame of a single 512-byte sector, taken from the user data FIFO. On a read it forwards the payload of incoming data frames to the read output. Both directions end when the device's register status frame arrives, and the status byte and an error flag go back to the requester.

The block keeps no payload storage of its own. A write sector passes straight from the user FIFO into the transmit FIFO, and the block starts it only when the user FIFO reports a full sector present. Framing, CRC, scrambling and the physical link lie outside the block and appear only as FIFO-style ports.

Top module: `fis_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1 and tx_valid, rd_valid and done are 0.
- R2: An accepted request emits five transmit words, tx_last on the fifth only. Word 0 holds 0x27 in bits 7:0, 1 in bit 15 and the command in bits 23:16: 0x35 for write, 0x25 for read. Word 1 is {0x40, lba[23:0]}. Word 2 is {0x00, lba[47:24]}. Word 3 is {16'h0, count}. Word 4 is zero.
- R3: A write request does not begin its command frame while usr_wlevel is below SECTOR_WORDS (128 words of 32 bits). It begins once the level reaches that value.
- R4: During a write, each received one-word frame with type byte 0x39 (bits 7:0) triggers one data frame, while sectors remain. The frame is header word 0x00000046 followed by SECTOR_WORDS user words in FIFO order, with tx_last on the final word. No data frame is sent without such a frame.
- R5: Every write data frame, not only the first, waits until usr_wlevel reaches SECTOR_WORDS before its header is sent.
- R6: During a read, the words that follow a received header of type 0x46 leave on rd_data in order, with rd_last on the frame's last word. The header word itself is not forwarded.
- R7: A received frame of type 0x34 ends the operation. Bits 23:16 of its first word are the status byte. done pulses for one cycle, in the cycle after the frame's last word is taken, with status_out holding that byte.
- R8: If bit 0 of the status byte is set, done_err is 1 with done. The block returns to idle and sends nothing more until a new request.
- R9: A received frame of any other type, or one not expected in the current direction, is consumed to its last word. It causes no rd_valid and no transmit word.
- R10: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last stay unchanged in the next cycle.
- R11: req_ready is 1 only when idle. A request presented while busy is ignored and does not alter the frames in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | 48 | Starting sector address |
| req_count | input | 16 | Number of sectors (nonzero) |
| usr_wdata | input | 32 | Head word of the user write FIFO |
| usr_wvalid | input | 1 | User write FIFO not empty |
| usr_wready | output | 1 | Pops the user write FIFO |
| usr_wlevel | input | 10 | Words held in the user write FIFO |
| tx_data | output | 32 | Word to the transmit FIFO |
| tx_last | output | 1 | Last word of a transmitted frame |
| tx_valid | output | 1 | Transmit word present |
| tx_ready | input | 1 | Transmit FIFO has room |
| rx_data | input | 32 | Word from the receive FIFO |
| rx_last | input | 1 | Last word of a received frame |
| rx_valid | input | 1 | Receive word present |
| rx_ready | output | 1 | Pops the receive FIFO |
| rd_data | output | 32 | Read payload word |
| rd_last | output | 1 | Last payload word of a data frame |
| rd_valid | output | 1 | Read payload word present |
| rd_ready | input | 1 | Requester takes the read word |
| done | output | 1 | One-cycle operation-end pulse |
| done_err | output | 1 | Device reported an error (with done) |
| status_out | output | 8 | Device status byte (with done) |

## Verification
The bench goes after the staging threshold. It holds the user FIFO at 100 words and then at 0 between sectors. A block that compares against the wrong level, or checks only before the command, would start a frame early and send words the FIFO does not have. It places foreign frames ahead of the expected ones, so a decoder that forwards them or loses frame alignment corrupts the read stream or the status. It throttles tx_ready at random, so a sequencer that advances without a handshake drops or repeats words. It sends an error status and knocks on req_valid during a busy read, so a block that retries or accepts a second request shows extra transmit words.

// File: rtl/fis_seq_pkg.sv
// Shared frame codes, command codes and state types of the command sequencer.
// Assumes 32-bit frame words with the frame type in bits 7:0 of the first word.
package fis_seq_pkg;
    localparam logic [7:0] FT_REG_H2D = 8'h27;
    localparam logic [7:0] FT_REG_D2H = 8'h34;
    localparam logic [7:0] FT_DMA_ACT = 8'h39;
    localparam logic [7:0] FT_DATA    = 8'h46;

    localparam logic [7:0] CMD_RD_DMA_EXT = 8'h25;
    localparam logic [7:0] CMD_WR_DMA_EXT = 8'h35;
    localparam logic [7:0] DEV_LBA_MODE   = 8'h40;

    typedef enum logic [1:0] {
        RX_STATUS,
        RX_ACTIVATE,
        RX_DATA,
        RX_OTHER
    } rx_kind_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAGE,
        S_CMD,
        S_LISTEN,
        S_DATA_HDR,
        S_DATA_PAY,
        S_RD_PAY,
        S_SKIP,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/fis_h2d_builder.sv
// Builds the five words of the host-to-device register frame.
// Purely combinational; the caller selects the word with idx (0..4).
module fis_h2d_builder
    import fis_seq_pkg::*;
#(
    parameter int LBA_W = 48,
    parameter int CNT_W = 16
) (
    input  logic [2:0]       idx,
    input  logic             is_write,
    input  logic [LBA_W-1:0] lba,
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      word,
    output logic             last
);
    localparam int LO_W = 24;
    localparam int HI_W = LBA_W - LO_W;

    logic [7:0] cmd;

    // Pick the DMA command code from the direction.
    always_comb cmd = is_write ? CMD_WR_DMA_EXT : CMD_RD_DMA_EXT;

    // Select the frame word for the current index.
    always_comb begin
        word = '0;
        unique case (idx)
            3'd0: word = {8'h00, cmd, 8'h80, FT_REG_H2D};
            3'd1: word = {DEV_LBA_MODE, lba[LO_W-1:0]};
            3'd2: word = {8'h00, {(LO_W-HI_W){1'b0}}, lba[LBA_W-1:LO_W]};
            3'd3: word = {{(32-CNT_W){1'b0}}, count};
            default: word = '0;
        endcase
    end

    // Flag the final word of the frame.
    always_comb last = (idx == 3'd4);
endmodule

// File: rtl/fis_rx_classify.sv
// Classifies a received frame from the type byte of its first word.
// Combinational; meaningful only while the word is a frame header.
module fis_rx_classify
    import fis_seq_pkg::*;
(
    input  logic [31:0] hdr,
    output rx_kind_t    kind
);
    // Map the type byte onto the frame kinds the sequencer acts on.
    always_comb begin
        unique case (hdr[7:0])
            FT_REG_D2H: kind = RX_STATUS;
            FT_DMA_ACT: kind = RX_ACTIVATE;
            FT_DATA:    kind = RX_DATA;
            default:    kind = RX_OTHER;
        endcase
    end
endmodule

// File: rtl/fis_beat_counter.sv
// Word counter within a frame: cleared on state change, stepped per word moved.
// Assumes clear and step never need to wrap within one frame.
module fis_beat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] value
);
    // Count accepted words, clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (clear) value <= '0;
        else if (step)  value <= value + 1'b1;
    end
endmodule

// File: rtl/fis_cmd_seq.sv
// Host command sequencer: turns a read/write sector request into the register,
// activation, data and status frame exchange. Write data streams straight from
// the user FIFO and a sector starts only when the FIFO holds a whole one.
// Assumes req_count is nonzero and usr_wvalid/usr_wlevel never shrink without a pop.
module fis_cmd_seq
    import fis_seq_pkg::*;
#(
    parameter int SECTOR_WORDS = 128,
    parameter int LBA_W        = 48,
    parameter int CNT_W        = 16,
    parameter int LVL_W        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LBA_W-1:0]  req_lba,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [31:0]       usr_wdata,
    input  logic              usr_wvalid,
    output logic              usr_wready,
    input  logic [LVL_W-1:0]  usr_wlevel,
    output logic [31:0]       tx_data,
    output logic              tx_last,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [31:0]       rx_data,
    input  logic              rx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [31:0]       rd_data,
    output logic              rd_last,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              done,
    output logic              done_err,
    output logic [7:0]        status_out
);
    localparam int BEAT_W = (SECTOR_WORDS > 8) ? $clog2(SECTOR_WORDS) : 3;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SECTOR_WORDS - 1);
    localparam logic [LVL_W-1:0]  FULL_LVL  = LVL_W'(SECTOR_WORDS);

    seq_state_t           state, state_n, skip_next, skip_next_n;
    logic                 op_write;
    logic [LBA_W-1:0]     op_lba;
    logic [CNT_W-1:0]     op_count;
    logic [CNT_W:0]       sec_left;
    logic [7:0]           stat_q;
    logic [BEAT_W-1:0]    beat;
    logic [31:0]          h2d_word;
    logic                 h2d_last;
    rx_kind_t             kind;
    logic                 staged, tx_hs, rx_hs;

    fis_h2d_builder #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_h2d (
        .idx      (beat[2:0]),
        .is_write (op_write),
        .lba      (op_lba),
        .count    (op_count),
        .word     (h2d_word),
        .last     (h2d_last)
    );

    fis_rx_classify u_cls (
        .hdr  (rx_data),
        .kind (kind)
    );

    fis_beat_counter #(.W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_n != state),
        .step  (tx_hs),
        .value (beat)
    );

    // Handshake and staging conditions.
    always_comb begin
        staged = (usr_wlevel >= FULL_LVL);
        tx_hs  = tx_valid && tx_ready;
        rx_hs  = rx_valid && rx_ready;
    end

    // Transmit side: command words, data header, or user payload.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_last  = 1'b0;
        unique case (state)
            S_CMD: begin
                tx_valid = 1'b1;
                tx_data  = h2d_word;
                tx_last  = h2d_last;
            end
            S_DATA_HDR: begin
                tx_valid = staged;
                tx_data  = {24'h0, FT_DATA};
            end
            S_DATA_PAY: begin
                tx_valid = usr_wvalid;
                tx_data  = usr_wdata;
                tx_last  = (beat == LAST_BEAT);
            end
            default: ;
        endcase
    end

    // Receive side, read output and requester handshake.
    always_comb begin
        usr_wready = (state == S_DATA_PAY) && tx_ready;
        rx_ready   = (state == S_LISTEN) || (state == S_SKIP) ||
                     ((state == S_RD_PAY) && rd_ready);
        rd_valid   = (state == S_RD_PAY) && rx_valid;
        rd_data    = rx_data;
        rd_last    = (state == S_RD_PAY) && rx_last;
        req_ready  = (state == S_IDLE);
        done       = (state == S_DONE);
        done_err   = (state == S_DONE) && stat_q[0];
        status_out = stat_q;
    end

    // Next-state choice for the frame sequence.
    always_comb begin
        state_n     = state;
        skip_next_n = skip_next;
        unique case (state)
            S_IDLE:  if (req_valid) state_n = req_write ? S_STAGE : S_CMD;
            S_STAGE: if (staged) state_n = S_CMD;
            S_CMD:   if (tx_hs && h2d_last) state_n = S_LISTEN;
            S_LISTEN: if (rx_valid) begin
                unique case (kind)
                    RX_STATUS: begin
                        skip_next_n = S_DONE;
                        state_n     = rx_last ? S_DONE : S_SKIP;
                    end
                    RX_ACTIVATE: begin
                        if (op_write && sec_left != '0) begin
                            skip_next_n = S_DATA_HDR;
                            state_n     = rx_last ? S_DATA_HDR : S_SKIP;
                        end else begin
                            skip_next_n = S_LISTEN;
                            state_n     = rx_last ? S_LISTEN : S_SKIP;
                        end
                    end
                    RX_DATA: begin
                        if (!op_write) begin
                            state_n = rx_last ? S_LISTEN : S_RD_PAY;
                        end else begin
                            skip_next_n = S_LISTEN;
                            state_n     = rx_last ? S_LISTEN : S_SKIP;
                        end
                    end
                    default: begin
                        skip_next_n = S_LISTEN;
                        state_n     = rx_last ? S_LISTEN : S_SKIP;
                    end
                endcase
            end
            S_SKIP:     if (rx_hs && rx_last) state_n = skip_next;
            S_DATA_HDR: if (tx_hs) state_n = S_DATA_PAY;
            S_DATA_PAY: if (tx_hs && beat == LAST_BEAT) state_n = S_LISTEN;
            S_RD_PAY:   if (rx_hs && rx_last) state_n = S_LISTEN;
            S_DONE:     state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            skip_next <= S_LISTEN;
        end else begin
            state     <= state_n;
            skip_next <= skip_next_n;
        end
    end

    // Operation fields, sectors remaining and captured status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_lba   <= '0;
            op_count <= '0;
            sec_left <= '0;
            stat_q   <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                op_write <= req_write;
                op_lba   <= req_lba;
                op_count <= req_count;
                sec_left <= {1'b0, req_count};
            end
            if (state == S_DATA_PAY && tx_hs && beat == LAST_BEAT)
                sec_left <= sec_left - 1'b1;
            if (state == S_LISTEN && rx_valid && kind == RX_STATUS)
                stat_q <= rx_data[23:16];
        end
    end
endmodule

// File: rtl/fis_cmd_seq_chk.sv
// Port-level protocol checks for the command sequencer, bound to every instance.
module fis_cmd_seq_chk #(
    parameter int SECTOR_WORDS = 128,
    parameter int LVL_W        = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [LVL_W-1:0] usr_wlevel,
    input logic             usr_wvalid,
    input logic             usr_wready,
    input logic [31:0]      tx_data,
    input logic             tx_last,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             done
);
    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R11
    req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R3
    stage_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write && (usr_wlevel < LVL_W'(SECTOR_WORDS)) |=> !tx_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready && !tx_valid);

    // R4
    pop_with_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_wready && usr_wvalid |-> tx_valid && tx_ready);
endmodule

bind fis_cmd_seq fis_cmd_seq_chk #(.SECTOR_WORDS(SECTOR_WORDS), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .usr_wlevel (usr_wlevel),
    .usr_wvalid (usr_wvalid),
    .usr_wready (usr_wready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .done       (done)
);

// File: tb/fis_cmd_seq_test.sv
// Bench: FIFO models on every stream, a scripted device, random ready throttling.
module fis_cmd_seq_test;
    localparam int SW = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [47:0] req_lba = '0;
    logic [15:0] req_count = '0;
    logic [31:0] usr_wdata = '0;
    logic        usr_wvalid = 1'b0, usr_wready;
    logic [9:0]  usr_wlevel = '0;
    logic [31:0] tx_data;
    logic        tx_last, tx_valid, tx_ready = 1'b1;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0, rx_valid = 1'b0, rx_ready;
    logic [31:0] rd_data;
    logic        rd_last, rd_valid, rd_ready = 1'b1;
    logic        done, done_err;
    logic [7:0]  status_out;

    fis_cmd_seq uut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] usr_q[$], pend_q[$];
    logic [32:0] rx_q[$], tx_got[$], rd_got[$], exp_tx[$], exp_rd[$];
    bit   rand_rdy = 1'b0, done_seen = 1'b0, hold_pend = 1'b0, got_err = 1'b0;
    logic [7:0]  got_stat = '0;
    logic [32:0] hold_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] h2d_word(int idx, bit wr, logic [47:0] lba, logic [15:0] cnt);
        case (idx)
            0: return {8'h00, (wr ? 8'h35 : 8'h25), 8'h80, 8'h27};
            1: return {8'h40, lba[23:0]};
            2: return {8'h00, lba[47:24]};
            3: return {16'h0, cnt};
            default: return 32'h0;
        endcase
    endfunction

    // Stream models: drive from queue heads, then record the handshakes.
    always @(negedge clk) begin
        cycles++;
        tx_ready   = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
        rd_ready   = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
        usr_wvalid = usr_q.size() > 0;
        usr_wdata  = usr_wvalid ? usr_q[0] : 32'h0;
        usr_wlevel = 10'(usr_q.size() > 1000 ? 1000 : usr_q.size());
        rx_valid   = rx_q.size() > 0;
        {rx_last, rx_data} = rx_valid ? rx_q[0] : 33'h0;
        #1;
        if (rst_n && hold_pend)  // R10 stall must hold the word
            chk(tx_valid && {tx_last, tx_data} == hold_word, "R10", "held tx word",
                {31'h0, tx_valid, tx_last, tx_data}, {31'h0, 1'b1, hold_word});
        hold_pend = tx_valid && !tx_ready;
        hold_word = {tx_last, tx_data};
        if (rx_valid && rx_ready) void'(rx_q.pop_front());
        if (usr_wvalid && usr_wready) void'(usr_q.pop_front());
        if (tx_valid && tx_ready) tx_got.push_back({tx_last, tx_data});
        if (rd_valid && rd_ready) rd_got.push_back({rd_last, rd_data});
        if (done) begin
            done_seen = 1'b1;
            got_stat  = status_out;
            got_err   = done_err;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(negedge clk) if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Build the device script and expected streams for one operation.
    task automatic prep(input bit wr, input logic [47:0] lba, input logic [15:0] cnt,
                        input logic [7:0] st, input bit junk);
        tx_got.delete(); rd_got.delete(); exp_tx.delete(); exp_rd.delete();
        pend_q.delete(); done_seen = 1'b0;
        if (junk) begin
            rx_q.push_back({1'b0, 32'h0000_005A});
            rx_q.push_back({1'b0, $urandom});
            rx_q.push_back({1'b1, $urandom});
        end
        for (int i = 0; i < 5; i++) exp_tx.push_back({i == 4, h2d_word(i, wr, lba, cnt)});
        for (int s = 0; s < int'(cnt); s++) begin
            if (wr) begin
                rx_q.push_back({1'b1, 32'h0000_0039});
                exp_tx.push_back({1'b0, 32'h0000_0046});
                for (int w = 0; w < SW; w++) begin
                    logic [31:0] d = $urandom;
                    pend_q.push_back(d);
                    exp_tx.push_back({w == SW - 1, d});
                end
            end else begin
                rx_q.push_back({1'b0, 32'h0000_0046});
                for (int w = 0; w < SW; w++) begin
                    logic [31:0] d = $urandom;
                    rx_q.push_back({w == SW - 1, d});
                    exp_rd.push_back({w == SW - 1, d});
                end
            end
        end
        rx_q.push_back({1'b0, 8'h00, st, 8'h40, 8'h34});
        for (int i = 1; i < 5; i++) rx_q.push_back({i == 4, 32'h0});
    endtask

    task automatic feed(input int n);
        for (int i = 0; i < n && pend_q.size() > 0; i++) usr_q.push_back(pend_q.pop_front());
    endtask

    task automatic issue(input bit wr, input logic [47:0] lba, input logic [15:0] cnt);
        @(negedge clk); #2;
        req_write = wr; req_lba = lba; req_count = cnt; req_valid = 1'b1;
        @(negedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 20000 && !done_seen; i++) @(negedge clk);
        #3;
    endtask

    task automatic check_op(input string req, input logic [7:0] st);
        int m = -1;
        chk(done_seen, "R7", "done pulse seen", done_seen, 1);
        chk(got_stat == st, "R7", "status byte", got_stat, st);
        chk(got_err == st[0], "R8", "error flag", got_err, st[0]);
        chk(tx_got.size() == exp_tx.size(), req, "tx word count", tx_got.size(), exp_tx.size());
        for (int i = 0; i < tx_got.size() && i < exp_tx.size(); i++)
            if (m < 0 && tx_got[i] != exp_tx[i]) m = i;
        chk(m < 0, req, "tx stream (R2/R4) first mismatch",
            m < 0 ? 0 : tx_got[m], m < 0 ? 0 : exp_tx[m]);
        m = -1;
        chk(rd_got.size() == exp_rd.size(), "R6", "read word count", rd_got.size(), exp_rd.size());
        for (int i = 0; i < rd_got.size() && i < exp_rd.size(); i++)
            if (m < 0 && rd_got[i] != exp_rd[i]) m = i;
        chk(m < 0, "R6", "read stream (R9 junk dropped)",
            m < 0 ? 0 : rd_got[m], m < 0 ? 0 : exp_rd[m]);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        #3;
        // R1 reset state
        chk(req_ready && !tx_valid && !rd_valid && !done, "R1", "reset outputs",
            {req_ready, tx_valid, rd_valid, done}, 4'b1000);
        @(negedge clk); rst_n = 1'b1;

        // R3 and R5: staging threshold before the command and before sector two.
        prep(1'b1, 48'h0000_1234_5678, 16'd2, 8'h50, 1'b0);
        feed(100);
        issue(1'b1, 48'h0000_1234_5678, 16'd2);
        repeat (40) @(negedge clk);
        #3 chk(tx_got.size() == 0, "R3", "no tx below a full sector", tx_got.size(), 0);
        feed(SW - 100);
        for (int i = 0; i < 2000 && tx_got.size() < 5 + SW + 1; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        #3 chk(tx_got.size() == 5 + SW + 1, "R5", "second sector held", tx_got.size(), 5 + SW + 1);
        feed(SW);
        wait_done();
        check_op("R4", 8'h50);

        // R11: read with requests knocked on while busy.
        prep(1'b0, 48'hABCD_EF01_2345, 16'd1, 8'h50, 1'b1);
        issue(1'b0, 48'hABCD_EF01_2345, 16'd1);
        req_write = 1'b1; req_lba = '1; req_count = 16'd7; req_valid = 1'b1;
        repeat (5) begin
            @(negedge clk); #3;
            chk(!req_ready, "R11", "busy refuses request", req_ready, 0);
        end
        req_valid = 1'b0;
        wait_done();
        check_op("R11", 8'h50);

        // R8: error status returns to idle without retry.
        prep(1'b1, 48'h0000_0000_0010, 16'd1, 8'h51, 1'b0);
        feed(SW);
        issue(1'b1, 48'h0000_0000_0010, 16'd1);
        wait_done();
        check_op("R8", 8'h51);
        tx_got.delete();
        repeat (20) @(negedge clk);
        #3 chk(tx_got.size() == 0 && req_ready, "R8", "idle, no retry after error",
               {tx_got.size(), req_ready}, 33'h1);

        // R2/R4/R6/R9/R10: random operations with throttled ready.
        rand_rdy = 1'b1;
        for (int k = 0; k < 6; k++) begin
            bit          wr  = $urandom % 2;
            logic [47:0] lba = {$urandom, $urandom};
            logic [15:0] cnt = 16'(1 + $urandom % 3);
            prep(wr, lba, cnt, 8'h50, ($urandom % 2) == 1);
            feed(pend_q.size());
            issue(wr, lba, cnt);
            wait_done();
            check_op(wr ? "R4" : "R2", 8'h50);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule